// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier

This block multiplies two floating-point numbers held in a format set by two parameters: the total width `W` and the exponent width `E`. Each word holds a sign bit in its top position, then an `E`-bit biased exponent, then a `W-E-1`-bit fraction. The significand of every finite nonzero value has an implied leading one. The bias is `2^(E-1)-1`. With the defaults (`W=16`, `E=5`) it handles the common 16-bit half-precision layout. Other widths, such as a 16-bit word with an 8-bit exponent, need only a change of parameter.

An operand pair arrives together with a qualifier. The product leaves two clock cycles later, from a register, with its own qualifier. A new pair can be accepted on every cycle. Tiny values are handled without gradual underflow. An operand whose exponent field is zero counts as zero, and a product that falls below the smallest normal magnitude is flushed to zero. Rounding is always to nearest, with ties going to the even significand. Any not-a-number result is a single canonical quiet pattern.

Top module: `fp_mul_pipe`

## Requirements
- R1: `res_valid` is high in exactly those cycles that come two rising edges after a cycle in which `in_valid` was sampled high, with reset low throughout. Each such `res` is the product of the operands sampled with that `in_valid`.
- R2: The sign of every zero, infinity and finite result is the XOR of the two operand signs.
- R3: For finite nonzero operands, the significands (with their hidden one) are multiplied and the unbiased exponents added. When the exact significand product is 2 or more, it is shifted right one place and the exponent raised by one.
- R4: The normalised significand is rounded to `W-E-1` fraction bits, to nearest, with ties to an even last bit. If rounding carries out of the significand, the result is shifted again and the exponent raised by one.
- R5: A biased result exponent of `2^E-1` or more, after rounding, yields infinity: exponent all ones and fraction zero.
- R6: A biased result exponent below 1, after rounding, yields zero: exponent and fraction all zero. No output ever has a zero exponent field with a nonzero fraction.
- R7: An operand whose exponent field is zero is treated as a zero of its sign, whatever its fraction holds.
- R8: A NaN operand (exponent all ones, fraction nonzero), or zero times infinity, yields the canonical quiet NaN. This is sign 0, exponent all ones, fraction top bit 1 and all other fraction bits 0 (`16'h7E00` by default). Every NaN output is exactly this value.
- R9: Infinity times infinity, or infinity times a finite nonzero value, yields an infinity.
- R10: While reset is high at a clock edge, the edge clears `res_valid` and `res` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `opa`/`opb` are to be multiplied |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| res_valid | output | 1 | `res` holds a product |
| res | output | W | Registered product |

## Verification
The bench targets the rounding boundaries, the range edges and the special values.

- **Rounding.** Exact ties are driven with both an odd and an even last bit. A design that rounds half up, or that truncates, is caught on these pairs. Products whose significand reaches or passes 2 are also driven. A design that drops the second normalisation after a rounding carry is caught there.
- **Range edges.** The largest finite value is multiplied by values just above and below one. If the overflow test runs before rounding, the result misses infinity. Tiny operands are squared. If the underflow flush is missing, a wrapped exponent or a denormal pattern escapes.
- **Special values.** Operands with a zero exponent field and a nonzero fraction are driven. So are zero times infinity, and NaN inputs of both signs. Any leak of an input fraction, any sign on a NaN, or any loss of the XOR sign on zero and infinity shows up against the reference model.
- **Pipeline timing.** Idle cycles are mixed into the stream. A design with the wrong pipeline depth, or with a stuck valid, is caught.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Operand or result class after decoding the exponent and fraction fields
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_class_e;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int W = 16,
  parameter int E = 5
) (
  input  logic [W-1:0]   word,
  output fp_class_e      cls,
  output logic           sgn,
  output logic [E-1:0]   expo,
  output logic [W-E-1:0] sig
);
  localparam int F = W - E - 1;

  logic [F-1:0] frac;
  logic         exp_zero;
  logic         exp_ones;

  assign sgn  = word[W-1];
  assign expo = word[W-2:F];
  assign frac = word[F-1:0];
  assign sig  = {1'b1, frac};

  assign exp_zero = (expo == '0);
  assign exp_ones = (expo == '1);

  always_comb begin
    if (exp_zero)          cls = CLS_ZERO;  // no subnormals: flush to zero
    else if (!exp_ones)    cls = CLS_NORM;
    else if (frac == '0)   cls = CLS_INF;
    else                   cls = CLS_NAN;
  end

endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
  import fpm_pkg::*;
#(
  parameter int W = 16,
  parameter int E = 5
) (
  input  fp_class_e                    cls,
  input  logic                         sgn,
  input  logic signed [E+1:0]          exp_in,
  input  logic [2*(W-E-1)+1:0]         prod,
  output logic [W-1:0]                 word
);
  localparam int F    = W - E - 1;
  localparam int XW   = E + 2;
  localparam int EMAX = (1 << E) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {E{1'b1}}, 1'b1, {(F-1){1'b0}}};

  logic                 hi;
  logic [F:0]           mant_pre;
  logic                 grd;
  logic                 stk;
  logic                 inc;
  logic [F+1:0]         sum;
  logic [F:0]           mant_fin;
  logic signed [XW-1:0] exp_n;
  logic signed [XW-1:0] exp_f;
  logic                 ovf;
  logic                 unf;

  // First normalisation: product in [1,4), shift right when >= 2
  assign hi       = prod[2*F+1];
  assign mant_pre = hi ? prod[2*F+1:F+1] : prod[2*F:F];
  assign grd      = hi ? prod[F] : prod[F-1];
  assign stk      = hi ? (|prod[F-1:0]) : (|prod[F-2:0]);
  assign exp_n    = exp_in + XW'(hi);

  // Round to nearest, ties to even
  assign inc      = grd & (stk | mant_pre[0]);
  assign sum      = {1'b0, mant_pre} + (F+2)'(inc);

  // Second normalisation on carry-out
  assign mant_fin = sum[F+1] ? sum[F+1:1] : sum[F:0];
  assign exp_f    = exp_n + XW'(sum[F+1]);

  assign ovf = (exp_f >= $signed(XW'(EMAX)));
  assign unf = (exp_f < $signed(XW'(1)));

  always_comb begin
    unique case (cls)
      CLS_NAN:  word = QNAN;
      CLS_INF:  word = {sgn, {E{1'b1}}, {F{1'b0}}};
      CLS_ZERO: word = {sgn, {(W-1){1'b0}}};
      default: begin
        if (ovf)      word = {sgn, {E{1'b1}}, {F{1'b0}}};
        else if (unf) word = {sgn, {(W-1){1'b0}}};
        else          word = {sgn, exp_f[E-1:0], mant_fin[F-1:0]};
      end
    endcase
  end

endmodule

// File: rtl/fp_mul_pipe.sv
module fp_mul_pipe
  import fpm_pkg::*;
#(
  parameter int W = 16,
  parameter int E = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         res_valid,
  output logic [W-1:0] res
);
  localparam int F    = W - E - 1;
  localparam int SW   = F + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = E + 2;
  localparam int BIAS = (1 << (E - 1)) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {E{1'b1}}, 1'b1, {(F-1){1'b0}}};

  // ---------------- operand decode ----------------
  logic [W-1:0]  op_w  [2];
  fp_class_e     op_c  [2];
  logic          op_s  [2];
  logic [E-1:0]  op_e  [2];
  logic [SW-1:0] op_m  [2];

  assign op_w[0] = opa;
  assign op_w[1] = opb;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpm_unpack #(.W(W), .E(E)) u_unpack (
      .word (op_w[i]),
      .cls  (op_c[i]),
      .sgn  (op_s[i]),
      .expo (op_e[i]),
      .sig  (op_m[i])
    );
  end

  // ---------------- stage 1: classify, exponent add, significand multiply ----
  fp_class_e            cls_c;
  logic                 any_nan;
  logic                 any_inf;
  logic                 any_zero;
  logic signed [XW-1:0] exp_sum_c;

  assign any_nan  = (op_c[0] == CLS_NAN) || (op_c[1] == CLS_NAN);
  assign any_inf  = (op_c[0] == CLS_INF) || (op_c[1] == CLS_INF);
  assign any_zero = (op_c[0] == CLS_ZERO) || (op_c[1] == CLS_ZERO);

  always_comb begin
    if (any_nan || (any_inf && any_zero)) cls_c = CLS_NAN;
    else if (any_inf)                     cls_c = CLS_INF;
    else if (any_zero)                    cls_c = CLS_ZERO;
    else                                  cls_c = CLS_NORM;
  end

  assign exp_sum_c = $signed({2'b00, op_e[0]}) + $signed({2'b00, op_e[1]})
                   - $signed(XW'(BIAS));

  logic                 s1_valid;
  fp_class_e            s1_cls;
  logic                 s1_sgn;
  logic signed [XW-1:0] s1_exp;
  logic [PW-1:0]        s1_prod;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_cls  <= cls_c;
      s1_sgn  <= op_s[0] ^ op_s[1];
      s1_exp  <= exp_sum_c;
      s1_prod <= op_m[0] * op_m[1];
    end
  end

  // ---------------- stage 2: normalise, round, pack ----------------
  logic [W-1:0] packed_c;

  fpm_round_pack #(.W(W), .E(E)) u_round (
    .cls    (s1_cls),
    .sgn    (s1_sgn),
    .exp_in (s1_exp),
    .prod   (s1_prod),
    .word   (packed_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) res <= packed_c;
    end
  end

  // ---------------- assertions ----------------
  AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid, 2)); // R1

  AST_VALID_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> res_valid); // R1

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res != QNAN) |->
      (res[W-1] == ($past(opa[W-1], 2) ^ $past(opb[W-1], 2)))); // R2

  AST_NO_DENORMAL_OUT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res[W-2:F] == '0) |-> (res[F-1:0] == '0)); // R6

  AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res[W-2:F] == '1 && res[F-1:0] != '0) |-> (res == QNAN)); // R8

endmodule

// File: tb/fp_mul_pipe_tb.sv
module fp_mul_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int E    = 5;
  localparam int F    = W - E - 1;
  localparam int EMAX = (1 << E) - 1;
  localparam int BIAS = (1 << (E - 1)) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {E{1'b1}}, 1'b1, {(F-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] opa, opb;
  logic         res_valid;
  logic [W-1:0] res;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    bit           v;
    logic [W-1:0] r;
    string        tag;
  } exp_t;
  exp_t pipe_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_mul_pipe #(.W(W), .E(E)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res(res)
  );

  // Behavioural reference: exact integer product, then round by remainder.
  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                           output string tag);
    int          ea = int'(a[W-2:F]);
    int          eb = int'(b[W-2:F]);
    longint      fa = longint'(a[F-1:0]);
    longint      fb = longint'(b[F-1:0]);
    bit          s  = a[W-1] ^ b[W-1];
    bit za = (ea == 0), zb = (eb == 0);
    bit ia = (ea == EMAX) && (fa == 0), ib = (eb == EMAX) && (fb == 0);
    bit na = (ea == EMAX) && (fa != 0), nb = (eb == EMAX) && (fb != 0);
    longint unsigned p, q, r, half;
    int e, sh;
    if (na || nb || (za && ib) || (ia && zb)) begin tag = "R8"; return QNAN; end
    if (ia || ib) begin tag = "R9"; return {s, {E{1'b1}}, {F{1'b0}}}; end
    if (za || zb) begin
      tag = ((za && fa != 0) || (zb && fb != 0)) ? "R7" : "R2";
      return {s, {(W-1){1'b0}}};
    end
    p  = longint'((64'd1 << F) | fa) * longint'((64'd1 << F) | fb);
    e  = ea + eb - BIAS;
    sh = F;
    if (p >= (64'd1 << (2*F+1))) begin sh = F + 1; e++; end
    q    = p >> sh;
    r    = p - (q << sh);
    half = 64'd1 << (sh - 1);
    tag  = "R3";
    if (r > half || (r == half && q[0])) begin q++; tag = "R4"; end
    if (q == (64'd1 << (F+1))) begin q = q >> 1; e++; end
    if (e >= EMAX) begin tag = "R5"; return {s, {E{1'b1}}, {F{1'b0}}}; end
    if (e < 1)     begin tag = "R6"; return {s, {(W-1){1'b0}}}; end
    return {s, E'(e), q[F-1:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] got,
                     input logic [W-1:0] want);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, want, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One cycle: compare the entry due now, then drive and enqueue the next.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input bit v);
    exp_t cur, nxt;
    @(negedge clk);
    cur = pipe_q.pop_front();
    if (cur.v) chk(res_valid === 1'b1 && res === cur.r, cur.tag, res, cur.r);
    else       chk(res_valid === 1'b0, "R1", {{(W-1){1'b0}}, res_valid}, '0);
    in_valid = v;
    opa = a;
    opb = b;
    nxt.v = v;
    nxt.r = v ? ref_mul(a, b, nxt.tag) : '0;
    if (!v) nxt.tag = "R1";
    pipe_q.push_back(nxt);
  endtask

  initial begin
    exp_t idle;
    idle.v = 0; idle.r = '0; idle.tag = "R1";
    rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid === 1'b0, "R10", {{(W-1){1'b0}}, res_valid}, '0);
    chk(res === '0, "R10", res, '0);
    rst = 1'b0;
    pipe_q.push_back(idle);
    pipe_q.push_back(idle);

    // R3 plain products, R2 signs
    step(16'h3C00, 16'h3C00, 1);  // 1*1
    step(16'h3E00, 16'h3E00, 1);  // 1.5*1.5, needs shift
    step(16'hC000, 16'h3C00, 1);  // -2*1
    step(16'h0000, 16'h0000, 0);
    // R4 ties: odd last bit rounds up, even stays
    step(16'h3C01, 16'h3E00, 1);
    step(16'h3C03, 16'h3E00, 1);
    step(16'h3C01, 16'h3C01, 1);
    step(16'h3FFF, 16'h3FFF, 1);
    step(16'h3DFF, 16'h3DFF, 1);
    // R5 overflow at and after rounding
    step(16'h7BFF, 16'h3C00, 1);
    step(16'h7BFF, 16'h3C01, 1);
    step(16'hFBFF, 16'h4000, 1);
    // R6 underflow, R7 zero-exponent operands
    step(16'h0400, 16'h0400, 1);
    step(16'h8400, 16'h3800, 1);
    step(16'h0001, 16'h3C00, 1);
    step(16'h83FF, 16'h7BFF, 1);
    // R8 NaN sources, R9 infinities
    step(16'h8000, 16'h7C00, 1);
    step(16'h7E00, 16'h3C00, 1);
    step(16'hFC01, 16'hBC00, 1);
    step(16'h7C00, 16'hC000, 1);
    step(16'hFC00, 16'hFC00, 1);
    step(16'h0000, 16'h0000, 0);

    // Random stream, exponents steered toward the range edges half the time
    for (int i = 0; i < 6000; i++) begin
      logic [W-1:0] a = W'($urandom);
      logic [W-1:0] b = W'($urandom);
      int sel = $urandom_range(0, 7);
      if (sel == 0) a[W-2:F] = E'($urandom_range(EMAX-1, EMAX));
      if (sel == 1) b[W-2:F] = E'($urandom_range(0, 2));
      if (sel == 2) begin a[W-2:F] = E'($urandom_range(BIAS-1, BIAS+1)); b[W-2:F] = E'(BIAS); end
      if (sel == 3) begin a[W-2:F] = E'($urandom_range(1, 8)); b[W-2:F] = E'($urandom_range(1, 8)); end
      step(a, b, ($urandom_range(0, 7) != 0));
    end
    step('0, '0, 0);
    step('0, '0, 0);
    done = 1;
    report();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1: watchdog expired got %0d expected %0d", 0, 1);
      report();
    end
  end

endmodule